// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block gathers interrupt lines into two banks of `LINES` lines each and turns them into two processor requests: a normal request (`irq_o`) and a fast request (`fiq_o`). Every line has its own configuration word. That word picks the request the line drives, whether the line is edge or level sensitive, and a 5-bit priority. Each bank keeps a pending word, a mask word, a register with the number of the line now being served, a control register for acknowledging, and a global delivery mask.

The second bank is cascaded. Its own normal request is fed into a chosen line of the first bank, and only the first bank drives the block outputs. Serving is handshaked. When a bank picks a winner, it holds the request and the winner's number until software writes the control register. Lines that arrive in the meantime are only recorded as pending.

Software reaches the block over a single-cycle register bus. Writes take effect at the clock edge, and reads are combinational. Address bit 8 picks the bank (0 for the first bank, 1 for the second). Bits 7:0 are the register offset inside the bank.

Top module: `bank_intc`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low. Every bank's mask word (offset 0x04) reads all ones, and its pending word (offset 0x00) reads zero.
- R2: A line whose mask bit is 1 still sets its pending bit, but it never raises a request. A mask bit of 0 enables the line.
- R3: The line configuration word is at offset 0x20 + 4·line. Its bit 1 selects the trigger. With bit 1 = 1 the line is level sensitive, and its pending bit follows the input one cycle later. With bit 1 = 0 a rising edge sets the pending bit, and the bit stays set after the input falls.
- R4: Among the unmasked pending lines routed to the normal request, the winner is the one with the lowest priority value (bits 6:2 of its configuration word). On a tie, the lowest line index wins. The winner's index reads at offset 0x10.
- R5: While a normal request is being served, `irq_o` stays high and the winner number stays frozen. A new arrival, even one with a better priority, only sets its pending bit.
- R6: Writing bit 0 = 1 to the control register (offset 0x18) ends the served normal request. `irq_o` is low in the next cycle, and the served line's edge pending bit is cleared. The next winner is latched one cycle later.
- R7: On the first bank, bit 0 = 1 in a configuration word routes the line to the fast request. It then raises `fiq_o` and not `irq_o`. Its index reads at offset 0x14, and writing bit 1 = 1 to the control register ends it.
- R8: On the second bank, the fast-routing bit is ignored. Such a line raises a normal request through the cascade, and `fiq_o` stays low.
- R9: Writing a word to the pending register clears every edge-sensitive pending bit at whose position the word holds a 0. Writing zero clears all edge-sensitive pending bits. Level-sensitive bits keep following their inputs.
- R10: Writing 1 to bit 0 of the global mask (offset 0x1C) blocks the bank's requests. Writing 0 enables them again, and a waiting line is then latched one cycle after the write.
- R11: The second bank's normal request is ORed into first-bank line `CASC_LINE` (default 0). Software acknowledges a cascaded request by writing the second bank's control register and then the first bank's.
- R12: A configuration word reads back the 7 bits last written to it, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 9 | Byte address; bit 8 picks the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| line_i | input | 2*LINES | Interrupt inputs; the low half feeds the first bank |
| irq_o | output | 1 | Normal processor request |
| fiq_o | output | 1 | Fast processor request |

## Verification
Three kinds of internal fault show up at the ports within one or two cycles:
- A corrupted served flag shows as `irq_o` or `fiq_o` rising or falling without a matching control or global-mask write.
- A wrong comparison in the arbiter shows as a winner number that differs from the minimum found by the bench.
- A stale edge or pending bit shows as a request that comes back after its acknowledge, or as a pending word that disagrees with the input history.

The cascade adds two register stages. A fault there shows as a top-level request that arrives at the wrong cycle, or that stays asserted after both banks are acknowledged.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BANK_OFS_W = 8;
    localparam int PRIO_W     = 5;

    localparam logic [BANK_OFS_W-1:0] OFS_PEND = 8'h00;
    localparam logic [BANK_OFS_W-1:0] OFS_MASK = 8'h04;
    localparam logic [BANK_OFS_W-1:0] OFS_INUM = 8'h10;
    localparam logic [BANK_OFS_W-1:0] OFS_FNUM = 8'h14;
    localparam logic [BANK_OFS_W-1:0] OFS_CTRL = 8'h18;
    localparam logic [BANK_OFS_W-1:0] OFS_GMSK = 8'h1C;
    localparam logic [BANK_OFS_W-1:0] OFS_CFG  = 8'h20;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        logic              fast;
    } line_cfg_t;
endpackage

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int LINES  = 32,
    parameter int PRIO_W = 5,
    localparam int IW    = $clog2(LINES)
) (
    input  logic [LINES-1:0]             req,
    input  logic [LINES-1:0][PRIO_W-1:0] prio,
    output logic                         valid,
    output logic [IW-1:0]                idx
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < LINES; i++) begin
            if (req[i] && (!valid || prio[i] < best)) begin
                valid = 1'b1;
                best  = prio[i];
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int LINES  = 32,
    parameter bit FIQ_OK = 1'b1,
    localparam int IW    = $clog2(LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LINES-1:0]      line_i,
    input  logic                  sel,
    input  logic                  wr,
    input  logic [BANK_OFS_W-1:0] ofs,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    output logic                  irq_o,
    output logic                  fiq_o
);
    typedef struct packed {
        logic [LINES-1:0]            pend;
        logic [LINES-1:0]            mask;
        logic [LINES-1:0]            prev;
        line_cfg_t [LINES-1:0]       cfg;
        logic                        irq_busy;
        logic [IW-1:0]               irq_num;
        logic                        fiq_busy;
        logic [IW-1:0]               fiq_num;
        logic                        gmask;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [LINES-1:0]             route_fast, irq_req, fiq_req;
    logic [LINES-1:0][PRIO_W-1:0] prio_v;
    logic                         irq_ok, fiq_ok;
    logic [IW-1:0]                irq_win, fiq_win;
    logic [BANK_OFS_W-1:0]        cfg_ofs;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            route_fast[i] = FIQ_OK && st_q.cfg[i].fast;
            prio_v[i]     = st_q.cfg[i].prio;
        end
        irq_req = st_q.pend & ~st_q.mask & ~route_fast;
        fiq_req = st_q.pend & ~st_q.mask & route_fast;
    end

    irqc_arbiter #(.LINES(LINES), .PRIO_W(PRIO_W)) i_irq_arb (
        .req(irq_req), .prio(prio_v), .valid(irq_ok), .idx(irq_win)
    );

    irqc_arbiter #(.LINES(LINES), .PRIO_W(PRIO_W)) i_fiq_arb (
        .req(fiq_req), .prio(prio_v), .valid(fiq_ok), .idx(fiq_win)
    );

    assign cfg_ofs = ofs - OFS_CFG;

    always_comb begin
        logic [LINES-1:0] clr;
        logic [LINES-1:0] rise;
        logic             bus_w;

        st_d  = st_q;
        bus_w = wr && sel;
        rise  = line_i & ~st_q.prev;
        clr   = '0;

        st_d.prev = line_i;

        if (bus_w && ofs == OFS_PEND) clr = clr | ~wdata[LINES-1:0];
        if (bus_w && ofs == OFS_MASK) st_d.mask = wdata[LINES-1:0];
        if (bus_w && ofs == OFS_GMSK) st_d.gmask = wdata[0];
        if (bus_w && ofs == OFS_CTRL) begin
            if (wdata[0] && st_q.irq_busy) begin
                st_d.irq_busy = 1'b0;
                clr = clr | (LINES'(1) << st_q.irq_num);
            end
            if (wdata[1] && st_q.fiq_busy) begin
                st_d.fiq_busy = 1'b0;
                clr = clr | (LINES'(1) << st_q.fiq_num);
            end
        end
        for (int i = 0; i < LINES; i++) begin
            if (bus_w && ofs >= OFS_CFG && cfg_ofs[1:0] == 2'b00
                && int'(cfg_ofs[BANK_OFS_W-1:2]) == i)
                st_d.cfg[i] = line_cfg_t'(wdata[6:0]);
            if (st_q.cfg[i].level) st_d.pend[i] = line_i[i];
            else st_d.pend[i] = (st_q.pend[i] & ~clr[i]) | rise[i];
        end

        if (!st_q.irq_busy && !st_q.gmask && irq_ok) begin
            st_d.irq_busy = 1'b1;
            st_d.irq_num  = irq_win;
        end
        if (!st_q.fiq_busy && !st_q.gmask && fiq_ok) begin
            st_d.fiq_busy = 1'b1;
            st_d.fiq_num  = fiq_win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_PEND: rdata = 32'(st_q.pend);
            OFS_MASK: rdata = 32'(st_q.mask);
            OFS_INUM: rdata = 32'(st_q.irq_num);
            OFS_FNUM: rdata = 32'(st_q.fiq_num);
            OFS_CTRL: rdata = {30'd0, st_q.fiq_busy, st_q.irq_busy};
            OFS_GMSK: rdata = {31'd0, st_q.gmask};
            default: begin
                for (int i = 0; i < LINES; i++)
                    if (ofs >= OFS_CFG && cfg_ofs[1:0] == 2'b00
                        && int'(cfg_ofs[BANK_OFS_W-1:2]) == i)
                        rdata = 32'(st_q.cfg[i]);
            end
        endcase
    end

    assign irq_o = st_q.irq_busy && !st_q.gmask;
    assign fiq_o = st_q.fiq_busy && !st_q.gmask;
endmodule

// File: rtl/bank_intc.sv
module bank_intc
    import irqc_pkg::*;
#(
    parameter int LINES     = 32,
    parameter int CASC_LINE = 0,
    localparam int ADDR_W   = BANK_OFS_W + 1,
    localparam int NBANK    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NBANK*LINES-1:0] line_i,
    output logic                   irq_o,
    output logic                   fiq_o
);
    logic [LINES-1:0] bank_in [NBANK];
    logic [31:0]      bank_rd [NBANK];
    logic [NBANK-1:0] bank_irq, bank_fiq;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        if (b == 0) begin : g_root
            always_comb begin
                bank_in[b] = line_i[LINES-1:0];
                bank_in[b][CASC_LINE] = line_i[CASC_LINE] | bank_irq[1];
            end
        end else begin : g_leaf
            assign bank_in[b] = line_i[b*LINES +: LINES];
        end

        irqc_bank #(.LINES(LINES), .FIQ_OK(b == 0)) i_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(bank_in[b]),
            .sel   (bus_addr[BANK_OFS_W] == 1'(b)),
            .wr    (bus_wr),
            .ofs   (bus_addr[BANK_OFS_W-1:0]),
            .wdata (bus_wdata),
            .rdata (bank_rd[b]),
            .irq_o (bank_irq[b]),
            .fiq_o (bank_fiq[b])
        );
    end

    assign bus_rdata = bank_rd[bus_addr[BANK_OFS_W]];
    assign irq_o     = bank_irq[0];
    assign fiq_o     = |bank_fiq;
endmodule

// File: rtl/bank_intc_chk.sv
module bank_intc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [8:0] bus_addr,
    input logic [1:0] wd,
    input logic       irq_o,
    input logic       fiq_o
);
    logic root_wr;
    assign root_wr = bus_wr && !bus_addr[8];

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !root_wr) |=> irq_o); // R5
    AST_FIQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_o && !root_wr) |=> fiq_o); // R7
    AST_IRQ_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && root_wr && bus_addr[7:0] == 8'h18 && wd[0]) |=> !irq_o); // R6
    AST_FIQ_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_o && root_wr && bus_addr[7:0] == 8'h18 && wd[1]) |=> !fiq_o); // R7
    AST_GMASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (root_wr && bus_addr[7:0] == 8'h1C && wd[0]) |=> (!irq_o && !fiq_o)); // R10
endmodule

bind bank_intc bank_intc_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .wd      (bus_wdata[1:0]),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o)
);

// File: tb/test_bank_intc.sv
module test_bank_intc;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] lines = '0;
    logic        irq_o, fiq_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_intc i_bank_intc (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_i(lines),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic int pick(input logic [31:0] set, input int pr [LINES]);
        int w = -1;
        for (int i = 0; i < LINES; i++)
            if (set[i] && (w < 0 || pr[i] < pr[w])) w = i;
        return w;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int pr [LINES];
        void'($urandom(32'd4242));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 irq", 32'(irq_o), 0);
        chk("R1 fiq", 32'(fiq_o), 0);
        rd(9'h004, v); chk("R1 mask0", v, 32'hFFFF_FFFF);
        rd(9'h104, v); chk("R1 mask1", v, 32'hFFFF_FFFF);
        rd(9'h000, v); chk("R1 pend0", v, 0);

        // R12 configuration readback
        wr(9'h020 + 9'd20, 32'hFFFF_FF7F);
        rd(9'h020 + 9'd20, v); chk("R12 cfg", v, 32'h7F);
        wr(9'h020 + 9'd20, 0);

        // R2 masked line pends but does not request
        lines[3] = 1'b1; tick(2);
        chk("R2 no irq", 32'(irq_o), 0);
        rd(9'h000, v); chk("R2 pend", v, 32'h8);
        lines[3] = 1'b0; tick(2);
        rd(9'h000, v); chk("R3 edge stays", v, 32'h8);
        // R3 level line
        wr(9'h020 + 9'd16, 32'h2);
        lines[4] = 1'b1; tick(1);
        rd(9'h000, v); chk("R3 level follows", v, 32'h18);
        // R9 write zero clears edge bits only
        wr(9'h000, 0);
        rd(9'h000, v); chk("R9 clear", v, 32'h10);
        lines[4] = 1'b0; tick(1);
        rd(9'h000, v); chk("R3 level drops", v, 0);
        wr(9'h020 + 9'd16, 0);

        // R5/R6 hold and acknowledge
        wr(9'h004, 32'h1);
        wr(9'h020 + 9'd28, 32'd10 << 2);
        wr(9'h020 + 9'd36, 32'd3 << 2);
        lines[7] = 1'b1; tick(2);
        chk("R6 irq up", 32'(irq_o), 1);
        rd(9'h010, v); chk("R4 num7", v, 7);
        lines[9] = 1'b1; tick(2);
        chk("R5 irq held", 32'(irq_o), 1);
        rd(9'h010, v); chk("R5 frozen", v, 7);
        rd(9'h000, v); chk("R5 pend9", v, 32'h280);
        wr(9'h018, 1);
        chk("R6 irq drops", 32'(irq_o), 0);
        tick(1);
        chk("R6 next irq", 32'(irq_o), 1);
        rd(9'h010, v); chk("R6 next num", v, 9);
        rd(9'h000, v); chk("R6 served cleared", v, 32'h200);
        wr(9'h018, 1);
        tick(1);
        chk("R6 idle", 32'(irq_o), 0);
        lines[9] = 1'b0; lines[7] = 1'b0; tick(1);

        // R4 random priority trials
        for (int t = 0; t < 20; t++) begin
            logic [31:0] set;
            set = $urandom & 32'hFFFF_FFFE;
            if (set == 0) set = 32'h4;
            if (t == 0) set = 32'hFFFF_FFFE;
            for (int i = 1; i < LINES; i++) begin
                pr[i] = (t == 0) ? 5 : int'($urandom_range(0, 31));
                wr(9'h020 + 9'(4 * i), 32'(pr[i]) << 2);
            end
            lines[31:0] = set; tick(2);
            while (set != 0) begin
                int w;
                w = pick(set, pr);
                chk("R4 irq", 32'(irq_o), 1);
                rd(9'h010, v); chk("R4 winner", v, 32'(w));
                wr(9'h018, 1);
                set[w] = 1'b0;
                tick(1);
            end
            chk("R4 drained", 32'(irq_o), 0);
            lines[31:0] = 0; tick(1);
        end

        // R10 global mask
        wr(9'h01C, 1);
        lines[2] = 1'b1; tick(2);
        chk("R10 blocked", 32'(irq_o), 0);
        wr(9'h01C, 0);
        tick(1);
        chk("R10 released", 32'(irq_o), 1);
        rd(9'h010, v); chk("R10 num", v, 2);
        wr(9'h018, 1);
        lines[2] = 1'b0; tick(2);

        // R7 fast route on bank 0
        wr(9'h020 + 9'd24, 32'h1);
        lines[6] = 1'b1; tick(2);
        chk("R7 fiq", 32'(fiq_o), 1);
        chk("R7 no irq", 32'(irq_o), 0);
        rd(9'h014, v); chk("R7 fnum", v, 6);
        wr(9'h018, 2);
        chk("R7 fiq drops", 32'(fiq_o), 0);
        lines[6] = 1'b0; tick(2);

        // R8/R11 cascade with ignored fast bit on bank 1
        wr(9'h020, 32'h2);
        wr(9'h004, 0);
        wr(9'h120 + 9'd16, 32'h1);
        wr(9'h104, ~32'h10);
        lines[36] = 1'b1; tick(4);
        chk("R8 irq via cascade", 32'(irq_o), 1);
        chk("R8 no fiq", 32'(fiq_o), 0);
        rd(9'h010, v); chk("R11 root num", v, 0);
        rd(9'h110, v); chk("R11 leaf num", v, 4);
        wr(9'h118, 1);
        wr(9'h018, 1);
        tick(2);
        chk("R11 both acked", 32'(irq_o), 0);
        lines[36] = 1'b0; tick(2);
        chk("R11 stays idle", 32'(irq_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule